// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Latency

This block buffers words between two unrelated clock domains. A producer pushes words on the write clock. A consumer drains them on the read clock, which may be faster or slower than the write clock. Each side keeps its own binary pointer and publishes a Gray-coded copy. The other side captures that copy through a two-stage synchronizer and converts it back to binary. Each side then derives its occupancy count and flags from its own pointer and the captured pointer of the other side.

A build-time parameter selects how the read port behaves. In standard mode, a read request made while the FIFO is not empty puts the word on the output register at the next read-clock edge, marked by a one-cycle valid pulse. In fall-through mode, an internal output register refills itself from memory whenever it is vacant. The head word therefore sits on the output as soon as the FIFO reports not empty, and it is consumed by the read request in the same cycle. The write-to-data latency is the same in both modes.

Each side exposes a word count and a programmable threshold flag, besides full and empty. A consumer can therefore gate its reads on a count guard rather than on the empty flag alone. Each domain has its own active-low reset. The reset is asserted asynchronously and released synchronously to that domain.

Top module: `xfifo_dc`

## Requirements
- R1: Once both resets are released, `empty`=1, `full`=0, `wr_count`=0, `rd_count`=0, `prog_empty`=1, `prog_full`=0 and `rd_valid`=0.
- R2: Every accepted word is delivered exactly once, in write order, in both read modes.
- R3: Standard mode (`RD_MODE`=RD_STD): a read-clock edge that samples `rd_en`=1 with `empty`=0 drives the head word on `rd_data` with `rd_valid`=1 after that same edge. `rd_valid` is 0 after every other edge.
- R4: Fall-through mode (`RD_MODE`=RD_FWFT): whenever `empty`=0, `rd_data` already holds the head word and `rd_valid`=1. An edge that samples `rd_en`=1 consumes it. While `rd_en`=0 the head stays put.
- R5: Consider a single write into an empty FIFO, with no reads. Counting read-clock edges from the first one after the write edge, `empty` falls after edge 2 in standard mode and after edge 3 in fall-through mode. In both modes, data is therefore usable after edge 3.
- R6: A read request while `empty`=1 is ignored. No word is lost, `rd_count` stays 0, and in standard mode `rd_valid` stays 0.
- R7: A write while `full`=1 is ignored. `wr_count` does not change and the word never appears at the read port.
- R8: `full`=1 exactly when `wr_count` equals 2**`ADDR_W`. `wr_count` counts words held in memory. In fall-through mode, a word moved into the output register leaves the write count but stays in `rd_count`.
- R9: `prog_full`=1 exactly when `wr_count` >= `PFULL_LVL`. `prog_empty`=1 exactly when `rd_count` <= `PEMPTY_LVL`.
- R10: Counts are conservative. `rd_count` never exceeds the number of words written and not yet read. `empty`=0 only when such a word exists. `wr_count` is never below the number of words still in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | No free slot in memory |
| prog_full | output | 1 | Write count at or above PFULL_LVL |
| wr_count | output | ADDR_W+2 | Words held in memory, as seen from the write side |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word register |
| rd_valid | output | 1 | rd_data holds a delivered (standard) or head (fall-through) word |
| empty | output | 1 | No word available for reading |
| prog_empty | output | 1 | Read count at or below PEMPTY_LVL |
| rd_count | output | ADDR_W+2 | Words available, as seen from the read side |

## Verification
A corrupted write or read pointer shows up at the read port within a few read cycles. The scoreboard then sees a word out of order, repeated or skipped, or sees `empty` drop with nothing outstanding. A wrong synchronized pointer shows as a count that leads the true occupancy, which the conservative-bound checks catch on the next edge of the affected domain. A wrong output-register state in fall-through mode changes `rd_data` or `rd_valid` while the head is not being consumed. A wrong state in standard mode shifts the valid pulse off the edge after the accepted request. Both errors are caught on the first affected read cycle.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/xfifo_gray_sync.sv
module xfifo_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside #(
  parameter int ADDR_W    = 4,
  parameter int PFULL_LVL = 12,
  localparam int PW       = ADDR_W + 1,
  localparam int CW       = ADDR_W + 2,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     rbin_s,
  output logic              mem_we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     wgray,
  output logic              full,
  output logic              prog_full,
  output logic [CW-1:0]     wr_count
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_d;

  always_comb begin
    wr_count  = {1'b0, wbin_q - rbin_s};
    full      = (wr_count == CW'(DEPTH));
    prog_full = (wr_count >= CW'(PFULL_LVL));
    mem_we    = wr_en & ~full;
    wbin_d    = wbin_q + PW'(mem_we);
    wgray_d   = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
    end else if (mem_we) begin
      wbin_q <= wbin_d;
      wgray  <= wgray_d;
    end
  end

  assign waddr = wbin_q[ADDR_W-1:0];
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
  import xfifo_pkg::*;
#(
  parameter int       DATA_W     = 8,
  parameter int       ADDR_W     = 4,
  parameter rd_mode_e RD_MODE    = RD_STD,
  parameter int       PEMPTY_LVL = 2,
  localparam int      PW         = ADDR_W + 1,
  localparam int      CW         = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [PW-1:0]     wbin_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rgray,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              prog_empty,
  output logic [CW-1:0]     rd_count
);
  logic [PW-1:0]     rbin_q, rbin_d, mem_cnt;
  logic              mem_empty, pop, vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;

  assign mem_cnt   = wbin_s - rbin_q;
  assign mem_empty = (mem_cnt == '0);

  generate
    if (RD_MODE == RD_FWFT) begin : g_fwft
      // Output register refills itself whenever it is vacant or being drained.
      assign pop      = ~mem_empty & (~vld_q | rd_en);
      assign vld_d    = pop | (vld_q & ~rd_en);
      assign empty    = ~vld_q;
      assign rd_count = {1'b0, mem_cnt} + {{(CW-1){1'b0}}, vld_q};
    end else begin : g_std
      assign pop      = rd_en & ~mem_empty;
      assign vld_d    = pop;
      assign empty    = mem_empty;
      assign rd_count = {1'b0, mem_cnt};
    end
  endgenerate

  always_comb begin
    rbin_d     = rbin_q + PW'(pop);
    data_d     = pop ? mem_rdata : data_q;
    prog_empty = (rd_count <= CW'(PEMPTY_LVL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      if (pop) begin
        rbin_q <= rbin_d;
        rgray  <= rbin_d ^ (rbin_d >> 1);
        data_q <= data_d;
      end
    end
  end

  assign raddr    = rbin_q[ADDR_W-1:0];
  assign rd_data  = data_q;
  assign rd_valid = vld_q;
endmodule

// File: rtl/xfifo_dc.sv
module xfifo_dc
  import xfifo_pkg::*;
#(
  parameter int       DATA_W     = 8,
  parameter int       ADDR_W     = 4,
  parameter rd_mode_e RD_MODE    = RD_STD,
  parameter int       PFULL_LVL  = 12,
  parameter int       PEMPTY_LVL = 2,
  localparam int      PW         = ADDR_W + 1,
  localparam int      CW         = ADDR_W + 2,
  localparam int      DEPTH      = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              prog_full,
  output logic [CW-1:0]     wr_count,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              prog_empty,
  output logic [CW-1:0]     rd_count
);
  logic              wrst_s_n, rrst_s_n, mem_we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wbin_s, rbin_s;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_rdata;

  xfifo_rst_sync u_wrst (.clk(wclk), .rst_n_in(wrst_n), .rst_n_out(wrst_s_n));
  xfifo_rst_sync u_rrst (.clk(rclk), .rst_n_in(rrst_n), .rst_n_out(rrst_s_n));

  xfifo_gray_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_s_n), .gray_in(rgray), .bin_out(rbin_s));
  xfifo_gray_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_s_n), .gray_in(wgray), .bin_out(wbin_s));

  xfifo_wside #(.ADDR_W(ADDR_W), .PFULL_LVL(PFULL_LVL)) u_wside (
    .clk(wclk), .rst_n(wrst_s_n), .wr_en(wr_en), .rbin_s(rbin_s),
    .mem_we(mem_we), .waddr(waddr), .wgray(wgray), .full(full),
    .prog_full(prog_full), .wr_count(wr_count));

  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= wr_data;
  end

  assign mem_rdata = mem[raddr];

  xfifo_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_MODE(RD_MODE),
                .PEMPTY_LVL(PEMPTY_LVL)) u_rside (
    .clk(rclk), .rst_n(rrst_s_n), .rd_en(rd_en), .wbin_s(wbin_s),
    .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(empty), .prog_empty(prog_empty),
    .rd_count(rd_count));
endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk
  import xfifo_pkg::*;
#(
  parameter int       ADDR_W  = 4,
  parameter rd_mode_e RD_MODE = RD_STD,
  localparam int      PW      = ADDR_W + 1,
  localparam int      CW      = ADDR_W + 2,
  localparam int      DEPTH   = 1 << ADDR_W
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wr_en,
  input logic          full,
  input logic          prog_full,
  input logic [CW-1:0] wr_count,
  input logic [PW-1:0] wgray,
  input logic          rclk,
  input logic          rrst_n,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          empty,
  input logic          prog_empty,
  input logic [PW-1:0] rgray
);
  // R2: published pointers move by one Gray bit at most per edge
  assert_gray_step_w_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_gray_step_r_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_no_overflow_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wgray));

  assert_count_bound_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_count <= CW'(DEPTH));

  assert_pfull_on_full_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> prog_full);

  generate
    if (RD_MODE == RD_STD) begin : g_std
      assert_rd_latency_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && !empty) |=> rd_valid);
      assert_no_underflow_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> (!rd_valid && $stable(rgray)));
      assert_pempty_on_empty_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |-> prog_empty);
    end else begin : g_fwft
      assert_head_hold_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!empty && !rd_en) |=> (!empty && rd_valid));
      assert_pempty_unused_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!empty && prog_empty) |-> rd_valid);
    end
  endgenerate
endmodule

bind xfifo_dc xfifo_chk #(.ADDR_W(ADDR_W), .RD_MODE(RD_MODE)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .full(full),
  .prog_full(prog_full), .wr_count(wr_count), .wgray(wgray),
  .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .empty(empty), .prog_empty(prog_empty), .rgray(rgray));

// File: tb/sim_xfifo_dc.sv
module sim_xfifo_dc;
  import xfifo_pkg::*;

  localparam int WCLK_PERIOD = 20;
  localparam int RCLK_PERIOD = 16;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int CW = AW + 2;
  localparam int DEPTH = 1 << AW;
  localparam int PF = 12;
  localparam int PE = 2;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n, rrst_n;
  logic wr_en0, wr_en1, rd_en0, rd_en1;
  logic [DW-1:0] wr_data, rd_data0, rd_data1;
  logic full0, full1, pfull0, pfull1, empty0, empty1, pempty0, pempty1;
  logic rd_valid0, rd_valid1;
  logic [CW-1:0] wr_count0, wr_count1, rd_count0, rd_count1;

  int n_chk = 0, n_fail = 0;
  int rmode = 0;
  bit rd_on = 0;
  logic [DW-1:0] q0[$], q1[$];
  logic [DW-1:0] seq = 8'h01;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #1;
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  // u0: standard read mode
  xfifo_dc #(.DATA_W(DW), .ADDR_W(AW), .RD_MODE(RD_STD), .PFULL_LVL(PF),
             .PEMPTY_LVL(PE)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en0), .wr_data(wr_data),
    .full(full0), .prog_full(pfull0), .wr_count(wr_count0),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en0), .rd_data(rd_data0),
    .rd_valid(rd_valid0), .empty(empty0), .prog_empty(pempty0),
    .rd_count(rd_count0));

  // u1: fall-through read mode
  xfifo_dc #(.DATA_W(DW), .ADDR_W(AW), .RD_MODE(RD_FWFT), .PFULL_LVL(PF),
             .PEMPTY_LVL(PE)) u1 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en1), .wr_data(wr_data),
    .full(full1), .prog_full(pfull1), .wr_count(wr_count1),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en1), .rd_data(rd_data1),
    .rd_valid(rd_valid1), .empty(empty1), .prog_empty(pempty1),
    .rd_count(rd_count1));

  function automatic bit exp_pfull(int c);  return c >= PF;   endfunction
  function automatic bit exp_pempty(int c); return c <= PE;   endfunction
  function automatic bit exp_full(int c);   return c == DEPTH; endfunction
  function automatic int exp_fill_edges(bit ft); return ft ? 3 : 2; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit want_read();
    case (rmode)
      1: return 1'b1;
      2: return ($urandom % 4) != 0;
      3: return ($urandom % 8) == 0;
      default: return 1'b0;
    endcase
  endfunction

  // one write-clock cycle: check write side, then drive
  task automatic wcycle(input bit e0, input bit e1, input logic [DW-1:0] d);
    @(negedge wclk);
    chk(int'(wr_count0) >= q0.size(), "R10", "std wr_count below memory words",
        int'(wr_count0), q0.size());
    chk(int'(wr_count1) + 1 >= q1.size(), "R10", "fwft wr_count below memory words",
        int'(wr_count1), q1.size() - 1);
    chk(full0 == exp_full(int'(wr_count0)), "R8", "std full vs wr_count",
        int'(full0), int'(exp_full(int'(wr_count0))));
    chk(full1 == exp_full(int'(wr_count1)), "R8", "fwft full vs wr_count",
        int'(full1), int'(exp_full(int'(wr_count1))));
    chk(pfull0 == exp_pfull(int'(wr_count0)), "R9", "std prog_full",
        int'(pfull0), int'(exp_pfull(int'(wr_count0))));
    chk(pfull1 == exp_pfull(int'(wr_count1)), "R9", "fwft prog_full",
        int'(pfull1), int'(exp_pfull(int'(wr_count1))));
    wr_en0  = e0;
    wr_en1  = e1;
    wr_data = d;
    if (e0 && !full0) q0.push_back(d);
    if (e1 && !full1) q1.push_back(d);
  endtask

  task automatic put_both();
    wcycle(1'b1, 1'b1, seq);
    seq = seq + 8'd1;
  endtask

  task automatic drain();
    rmode = 1;
    while (q0.size() != 0 || q1.size() != 0 || !empty0 || !empty1)
      wcycle(1'b0, 1'b0, '0);
    repeat (8) wcycle(1'b0, 1'b0, '0);   // reads while empty
    chk(rd_count0 == '0 && empty0, "R6", "std count after reads on empty",
        int'(rd_count0), 0);
    chk(rd_count1 == '0 && empty1, "R6", "fwft count after reads on empty",
        int'(rd_count1), 0);
    chk(rd_valid0 == 1'b0, "R6", "std rd_valid after reads on empty",
        int'(rd_valid0), 0);
    rmode = 0;
    repeat (4) wcycle(1'b0, 1'b0, '0);
    chk(wr_count0 == '0 && wr_count1 == '0, "R8", "wr_count after drain",
        int'(wr_count0) + int'(wr_count1), 0);
  endtask

  // read-side process: checks and read requests on every read negedge
  logic [DW-1:0] exp0;
  bit pend0 = 0;
  initial begin
    bit r0, r1;
    rd_en0 = 1'b0;
    rd_en1 = 1'b0;
    forever begin
      @(negedge rclk);
      if (rd_on) begin
        if (pend0) begin
          chk(rd_valid0 === 1'b1, "R3", "std rd_valid after accepted read",
              int'(rd_valid0), 1);
          chk(rd_data0 === exp0, "R2", "std read data order",
              int'(rd_data0), int'(exp0));
        end else begin
          chk(rd_valid0 === 1'b0, "R3", "std rd_valid without accepted read",
              int'(rd_valid0), 0);
        end
        chk(int'(rd_count0) <= q0.size(), "R10", "std rd_count above stored",
            int'(rd_count0), q0.size());
        chk(pempty0 == exp_pempty(int'(rd_count0)), "R9", "std prog_empty",
            int'(pempty0), int'(exp_pempty(int'(rd_count0))));
        chk(rd_valid1 === !empty1, "R4", "fwft rd_valid vs empty",
            int'(rd_valid1), int'(!empty1));
        chk(int'(rd_count1) <= q1.size(), "R10", "fwft rd_count above stored",
            int'(rd_count1), q1.size());
        chk(pempty1 == exp_pempty(int'(rd_count1)), "R9", "fwft prog_empty",
            int'(pempty1), int'(exp_pempty(int'(rd_count1))));
        if (!empty1) begin
          if (q1.size() == 0)
            chk(1'b0, "R10", "fwft not empty with nothing stored", 0, 1);
          else
            chk(rd_data1 === q1[0], "R4", "fwft head word on rd_data",
                int'(rd_data1), int'(q1[0]));
        end
        r0 = want_read();
        r1 = want_read();
        rd_en0 = r0;
        pend0  = r0 && !empty0;
        if (pend0) begin
          if (q0.size() == 0) begin
            chk(1'b0, "R10", "std not empty with nothing stored", 0, 1);
            pend0 = 0;
          end else begin
            exp0 = q0.pop_front();
          end
        end
        rd_en1 = r1;
        if (r1 && !empty1 && q1.size() != 0) void'(q1.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge wclk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int f0, f1;
    void'($urandom(32'd20240611));
    wrst_n = 1'b0; rrst_n = 1'b0;
    wr_en0 = 1'b0; wr_en1 = 1'b0; wr_data = '0;
    repeat (4) @(negedge wclk);
    wrst_n = 1'b1;
    @(negedge rclk);
    rrst_n = 1'b1;
    repeat (6) @(negedge wclk);

    // R1: state after reset
    chk(empty0 && empty1, "R1", "empty after reset", int'(empty0 & empty1), 1);
    chk(!full0 && !full1, "R1", "full after reset", int'(full0 | full1), 0);
    chk(wr_count0 == '0 && rd_count0 == '0 && wr_count1 == '0 && rd_count1 == '0,
        "R1", "counts after reset",
        int'(wr_count0) + int'(rd_count0) + int'(wr_count1) + int'(rd_count1), 0);
    chk(pempty0 && pempty1 && !pfull0 && !pfull1, "R1", "threshold flags after reset",
        int'({pempty0, pempty1, pfull0, pfull1}), 4'b1100);
    chk(!rd_valid0 && !rd_valid1, "R1", "rd_valid after reset",
        int'(rd_valid0 | rd_valid1), 0);
    rd_on = 1;

    // R5: first-word latency with reads idle
    @(negedge wclk);
    wr_en0 = 1'b1; wr_en1 = 1'b1; wr_data = seq;
    q0.push_back(seq); q1.push_back(seq);
    seq = seq + 8'd1;
    @(posedge wclk);
    #1 wr_en0 = 1'b0; wr_en1 = 1'b0;
    f0 = 0; f1 = 0;
    for (int n = 1; n <= 6; n++) begin
      @(posedge rclk);
      @(negedge rclk);
      if (!empty0 && f0 == 0) f0 = n;
      if (!empty1 && f1 == 0) f1 = n;
    end
    chk(f0 == exp_fill_edges(1'b0), "R5", "std edges until not empty", f0,
        exp_fill_edges(1'b0));
    chk(f1 == exp_fill_edges(1'b1), "R5", "fwft edges until not empty", f1,
        exp_fill_edges(1'b1));
    drain();

    // fill to full with reads idle
    repeat (DEPTH) put_both();
    repeat (10) wcycle(1'b0, 1'b0, '0);
    chk(full0 && wr_count0 == CW'(DEPTH), "R8", "std full after depth writes",
        int'(wr_count0), DEPTH);
    chk(!full1 && wr_count1 == CW'(DEPTH - 1), "R8", "fwft wr_count excludes output word",
        int'(wr_count1), DEPTH - 1);
    chk(rd_count0 == CW'(DEPTH) && rd_count1 == CW'(DEPTH), "R8", "rd_count after fill",
        int'(rd_count0) + int'(rd_count1), 2 * DEPTH);
    chk(pfull0 && !pempty0, "R9", "std thresholds when full",
        int'({pfull0, pempty0}), 2'b10);

    // R7: writes while full are dropped
    repeat (3) wcycle(1'b1, 1'b0, 8'hEE);
    repeat (3) wcycle(1'b0, 1'b0, '0);
    chk(wr_count0 == CW'(DEPTH) && full0, "R7", "wr_count after write on full",
        int'(wr_count0), DEPTH);
    drain();

    // random traffic in several rate mixes
    for (int ph = 0; ph < 4; ph++) begin
      rmode = (ph == 1) ? 3 : 2;
      for (int i = 0; i < 1200; i++) begin
        bit w;
        case (ph)
          0: w = ($urandom % 4) != 0;
          1: w = ($urandom % 2) != 0;
          2: w = ($urandom % 4) == 0;
          default: w = ($urandom % 2) != 0;
        endcase
        if (w) put_both();
        else   wcycle(1'b0, 1'b0, '0);
      end
    end
    drain();
    report();
  end
endmodule